// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a single register write into software interrupts raised between processors. The write word names one of sixteen interrupt numbers, a list of target processors and a filter that chooses how that list is read. The block adds the selected targets to a pending record for that interrupt number. The record keeps, for every interrupt number, one 8-bit lane per sending processor. Inside each lane there is one bit per receiving processor, so a receiver can tell which sender raised the interrupt.

A target whose processor interface enable input is low is skipped and gets no pending bit. The whole pending matrix is driven on one flat output bus. Each write takes effect at the next clock edge. Bits are only ever set here. Clearing them on acknowledge belongs to logic outside this block, so only reset clears them.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every bit of the pending output is 0.
- R2: A write updates the pending output at the clock edge where the strobe is sampled high. With the strobe low, the output holds its value.
- R3: Write word fields: the interrupt number is bits [3:0], the target list is bits [23:16] and the filter is bits [25:24]. All other bits have no effect. Pending bit for interrupt n, sender s and target t sits at output position 32*n + 8*s + t.
- R4: With filter 0, every processor whose target-list bit is set receives the interrupt.
- R5: With filter 1, every processor except the requester receives the interrupt, and the list is ignored.
- R6: With filter 2, only the requester receives the interrupt, and the list is ignored.
- R7: Filter 3 is reserved, and a write using it changes nothing.
- R8: A selected target whose enable input is low gets no pending bit.
- R9: Target-list bits at or above the processor count (bits [23:20] with four processors) are ignored.
- R10: Pending bits only accumulate. Setting a bit that is already pending changes nothing else, and no write clears a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the software-interrupt register |
| wr_data | input | 32 | Write word holding the interrupt number, target list and filter |
| req_id | input | 2 | Number of the processor making the write |
| cpu_en | input | 4 | Interface enable input, one per processor |
| pend | output | 512 | Pending matrix: 16 words of 4 lanes by 8 bits |

## Verification
The hardest case to reach is a write whose result is nothing at all. This covers a reserved filter, a self-targeted interrupt while the requester's interface is disabled, and a list that names only processors outside the configured count. Each of these leaves the output as it was, so it cannot be told apart from a write that was simply lost. The stimulus first fills several interrupt words with known bits from earlier writes. It then issues each no-effect write and compares the whole 512-bit matrix against the model on the following cycle. A repeat of an earlier write is checked the same way, to show that an already-set bit is left alone.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU = 4,
  parameter int NSGI = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [31:0]                    wr_data,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] req_id,
  input  logic [NCPU-1:0]                cpu_en,
  output logic [NSGI*8*NCPU-1:0]         pend
);
  localparam int LANE = 8;
  localparam int WW   = LANE * NCPU;
  localparam int IDW  = (NSGI > 1) ? $clog2(NSGI) : 1;

  logic [NSGI-1:0][WW-1:0] pend_q;
  logic [IDW-1:0]  sgi_id;
  logic [1:0]      filt;
  logic [NCPU-1:0] listv, self_oh, sel;
  logic            unused_ok;

  assign sgi_id    = wr_data[IDW-1:0];
  assign filt      = wr_data[25:24];
  assign listv     = wr_data[16 +: NCPU];
  assign self_oh   = {{(NCPU-1){1'b0}}, 1'b1} << req_id;
  assign unused_ok = &{1'b0, wr_data};

  always_comb begin
    case (filt)
      2'd0:    sel = listv;
      2'd1:    sel = ~self_oh;
      2'd2:    sel = self_oh;
      default: sel = '0;
    endcase
    sel = sel & cpu_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= '0;
    else if (wr_en)
      pend_q[sgi_id][req_id*LANE +: NCPU] <= pend_q[sgi_id][req_id*LANE +: NCPU] | sel;
  end

  assign pend = pend_q;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_q));

  a_r7_reserved_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && filt == 2'd3) |=> $stable(pend_q));

  a_r8_self_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && filt == 2'd2 && !cpu_en[req_id]) |=> $stable(pend_q));

  a_r6_self_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && filt == 2'd2 && cpu_en[req_id])
      |=> pend_q[$past(sgi_id)][$past(req_id)*LANE + $past(req_id)]);

  a_r10_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(pend_q)) == $past(pend_q));
endmodule

// File: tb/sim_sgi_dispatch.sv
module sim_sgi_dispatch;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [1:0]   req_id = '0;
  logic [3:0]   cpu_en = 4'hF;
  logic [511:0] pend;

  logic [15:0][31:0] model = '0;
  logic [511:0] expq[$];
  string        tagq[$];
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .req_id(req_id), .cpu_en(cpu_en), .pend(pend)
  );

  function automatic logic [31:0] word(input logic [1:0] f, input logic [7:0] lst,
                                       input logic [3:0] id);
    return {6'b0, f, lst, 12'h0, id};
  endfunction

  task automatic send(input logic [31:0] d, input logic [1:0] r,
                      input logic [3:0] en, input string tag);
    logic [3:0] t;
    logic [3:0] self;
    @(negedge clk);
    self = 4'b0001 << r;
    case (d[25:24])
      2'd0: t = d[19:16];
      2'd1: t = ~self;
      2'd2: t = self;
      default: t = 4'h0;
    endcase
    t = t & en;
    model[d[3:0]][8*r +: 4] = model[d[3:0]][8*r +: 4] | t;
    wr_en = 1'b1; wr_data = d; req_id = r; cpu_en = en;
    expq.push_back(model);
    tagq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'hFFFF_FFFF;
    expq.push_back(model);
    tagq.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [511:0] e;
        string tg;
        e  = expq.pop_front();
        tg = tagq.pop_front();
        n_chk++;
        if (pend !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", tg, pend, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (pend !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got %h expected 0", pend);
    end
    send(word(2'd0, 8'h05, 4'd3), 2'd1, 4'hF, "R4 list 0x05 from cpu1");
    idle("R2 hold with strobe low");
    send(word(2'd1, 8'h00, 4'd7), 2'd2, 4'hF, "R5 all but requester");
    send(word(2'd2, 8'hFF, 4'd0), 2'd3, 4'hF, "R6 self only");
    send(word(2'd3, 8'h0F, 4'd5), 2'd0, 4'hF, "R7 reserved filter");
    send(word(2'd0, 8'h0F, 4'd9), 2'd0, 4'b0101, "R8 disabled targets skipped");
    send(word(2'd2, 8'h00, 4'd10), 2'd1, 4'b1101, "R8 self disabled");
    send(word(2'd0, 8'hF0, 4'd11), 2'd2, 4'hF, "R9 high list bits ignored");
    send(word(2'd0, 8'h05, 4'd3), 2'd1, 4'hF, "R10 repeat is no-op");
    send(word(2'd0, 8'h02, 4'd3), 2'd1, 4'hF, "R10 accumulate");
    send(32'hFC08_FFFF, 2'd0, 4'hF, "R3 field positions");
    send(word(2'd1, 8'h00, 4'd3), 2'd3, 4'hF, "R3 second sender lane");
    idle("R2 final hold");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule